// File: doc/BRIEF.md
# Serial-Bus Node Core Register File

This block is the control and status register file of a serial-bus node. Each request arrives as a one-cycle strobe. The strobe carries a byte offset into the register space, a transfer length in bytes, a read/write flag and one quadlet of write data. One cycle later the block returns a response code, which is complete (0), type error (6) or address error (7), together with a read quadlet.

The block holds the following registers:
- a node identifier, whose bus field software may rewrite;
- a two-part split-transaction timeout, from which it derives an expiry period in microseconds with a floor of 100 ms;
- a cycle-time register, loaded from an external cycle-counter sample or by a write;
- a bus-time register, which advances by 128 each time a new cycle-time sample is smaller than the one before;
- a broadcast-channel register, in which only the valid flag can be written.

The bandwidth, channel and bus-manager resource registers are owned by a separate compare-swap unit. Their current values come in on input ports and are returned on reads. Plain writes to them are refused.

The control is a two-state machine. `ST_IDLE` means no response is pending. `ST_RESP` means a response is being presented.
- `ST_IDLE` goes to `ST_RESP` on a strobe.
- `ST_RESP` stays in `ST_RESP` on a back-to-back strobe.
- `ST_RESP` returns to `ST_IDLE` when there is no strobe.

Top module: `sbus_csr_regfile`

## Requirements
- R1: A request accepted at a clock edge makes `rsp_valid` high for the next cycle. In that cycle `rsp_code` and `rsp_rdata` are valid. The control moves `ST_IDLE`→`ST_RESP` on a strobe, stays in `ST_RESP` on a back-to-back strobe, and returns to `ST_IDLE` otherwise.
- R2: The response is type error (6) whenever `req_offset` or `req_len` is not a multiple of four. This check applies at any offset and takes precedence over address decoding.
- R3: Aligned accesses to the busy-timeout offset 0x210, or to any offset not listed in R4 to R12, return address error (7).
- R4: The resource offsets are 0x21C (bus manager), 0x220 (bandwidth), 0x224 (channels high) and 0x228 (channels low). A read of one of them returns the matching input port. A write to one of them returns type error (6).
- R5: A read of reset-start (0x00C) returns type error (6). A write to it returns complete and has no effect. The state offsets 0x000 and 0x004 read as 0, and writes to them complete with no effect.
- R6: Split-high (0x018) keeps only write bits 2:0 and resets to 0. Split-low (0x01C) keeps only write bits 31:19 and resets to 800<<19.
- R7: `expire_us` equals hi×1,000,000 + (lo>>19)×125, raised to 100,000 if it is smaller. It reflects a split-timeout write in the cycle that follows the write.
- R8: Cycle-time (0x200) reads the most recent value it received, whether that value came from `cyc_sample` (taken while `cyc_sample_valid` is high) or from a write. A write takes priority over a sample in the same cycle. Cycle-time resets to 0.
- R9: Bus time advances by 128 when an accepted sample is smaller than the stored cycle time.
- R10: A bus-time (0x204) read returns bus_time OR (cycle_time>>25). A bus-time write keeps only bits 31:7. Bus time resets to 0.
- R11: The broadcast-channel register (0x234) resets to 0x8000001F. A write changes only bit 30.
- R12: A node-ID (0x008) write replaces bits 31:22, the bus field, and keeps bits 21:16, the node field. Reads return the register in bits 31:16 with zeros below. `node_id` shows the same 16 bits. The register resets to `RESET_NODE_ID`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | OFS_W | Byte offset into the register space |
| req_len | input | LEN_W | Transfer length in bytes |
| req_wdata | input | 32 | Write quadlet |
| cyc_sample_valid | input | 1 | New cycle-counter sample present |
| cyc_sample | input | 32 | Cycle-counter sample |
| res_bm_id | input | 32 | Current bus-manager-ID value |
| res_bw_avail | input | 32 | Current bandwidth-available value |
| res_chan_hi | input | 32 | Current channels-available high value |
| res_chan_lo | input | 32 | Current channels-available low value |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 4 | Response code: 0 complete, 6 type error, 7 address error |
| rsp_rdata | output | 32 | Read quadlet, or 0 for a write or an error |
| node_id | output | 16 | Node-ID register, bus field and node field |
| expire_us | output | EXP_W | Split-transaction expiry period in microseconds |

## Verification
Every offset in the 1 KiB space is read once, and lengths 0 to 15 are swept at one offset. Together these separate the alignment rule from address decoding and show which offsets are gaps. The expiry output is driven by a grid that crosses every seconds value with unit counts below, at and above the floor point. This grid tells a missing clamp apart from a correct formula.

Cycle-time samples are fed in two ways:
- rising runs, which must leave bus time unchanged;
- descending steps, which must add 128.

Samples with high bits set then show the OR term in bus-time reads. All-ones writes to the masked registers show which bits each register keeps.

// File: rtl/sbus_csr_pkg.sv
package sbus_csr_pkg;

    typedef enum logic [3:0] {
        RC_COMPLETE = 4'd0,
        RC_TYPE_ERR = 4'd6,
        RC_ADDR_ERR = 4'd7
    } rcode_e;

    typedef enum logic [3:0] {
        SEL_STATE,
        SEL_RESET,
        SEL_NODE,
        SEL_SPLIT_HI,
        SEL_SPLIT_LO,
        SEL_CYCLE,
        SEL_BUS,
        SEL_BM,
        SEL_BW,
        SEL_CHHI,
        SEL_CHLO,
        SEL_BCAST,
        SEL_NONE
    } regsel_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } ctl_state_e;

    localparam int OFS_STATE_CLR = 'h000;
    localparam int OFS_STATE_SET = 'h004;
    localparam int OFS_NODE      = 'h008;
    localparam int OFS_RESET     = 'h00C;
    localparam int OFS_SPLIT_HI  = 'h018;
    localparam int OFS_SPLIT_LO  = 'h01C;
    localparam int OFS_CYCLE     = 'h200;
    localparam int OFS_BUS       = 'h204;
    localparam int OFS_BUSY      = 'h210;
    localparam int OFS_BM        = 'h21C;
    localparam int OFS_BW        = 'h220;
    localparam int OFS_CHHI      = 'h224;
    localparam int OFS_CHLO      = 'h228;
    localparam int OFS_BCAST     = 'h234;

endpackage

// File: rtl/sbus_csr_decode.sv
module sbus_csr_decode
    import sbus_csr_pkg::*;
#(
    parameter int OFS_W = 10,
    parameter int LEN_W = 12
) (
    input  logic [OFS_W-1:0] offset,
    input  logic [LEN_W-1:0] len,
    input  logic             is_write,
    output regsel_e          sel,
    output rcode_e           code
);

    always_comb begin
        unique case (int'(offset))
            OFS_STATE_CLR, OFS_STATE_SET: sel = SEL_STATE;
            OFS_RESET:                    sel = SEL_RESET;
            OFS_NODE:                     sel = SEL_NODE;
            OFS_SPLIT_HI:                 sel = SEL_SPLIT_HI;
            OFS_SPLIT_LO:                 sel = SEL_SPLIT_LO;
            OFS_CYCLE:                    sel = SEL_CYCLE;
            OFS_BUS:                      sel = SEL_BUS;
            OFS_BM:                       sel = SEL_BM;
            OFS_BW:                       sel = SEL_BW;
            OFS_CHHI:                     sel = SEL_CHHI;
            OFS_CHLO:                     sel = SEL_CHLO;
            OFS_BCAST:                    sel = SEL_BCAST;
            default:                      sel = SEL_NONE;
        endcase
    end

    always_comb begin
        if ((offset[1:0] != 2'b00) || (len[1:0] != 2'b00))
            code = RC_TYPE_ERR;
        else if (sel == SEL_NONE)
            code = RC_ADDR_ERR;
        else if (is_write && (sel inside {SEL_BM, SEL_BW, SEL_CHHI, SEL_CHLO}))
            code = RC_TYPE_ERR;
        else if (!is_write && sel == SEL_RESET)
            code = RC_TYPE_ERR;
        else
            code = RC_COMPLETE;
    end

endmodule

// File: rtl/sbus_csr_expiry.sv
module sbus_csr_expiry #(
    parameter int EXP_W   = 24,
    parameter int SEC_US  = 1000000,
    parameter int TICK_US = 125,
    parameter int MIN_US  = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       secs,
    input  logic [12:0]      ticks,
    output logic [EXP_W-1:0] expire_us
);

    logic [EXP_W-1:0] raw_us;

    always_comb begin
        raw_us = EXP_W'(secs) * EXP_W'(SEC_US) + EXP_W'(ticks) * EXP_W'(TICK_US);
        expire_us = (raw_us < EXP_W'(MIN_US)) ? EXP_W'(MIN_US) : raw_us;
    end

    assert_expire_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        expire_us >= EXP_W'(MIN_US));

    assert_expire_from_secs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        expire_us >= EXP_W'(secs) * EXP_W'(SEC_US));

endmodule

// File: rtl/sbus_csr_bustime.sv
module sbus_csr_bustime (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sample_valid,
    input  logic [31:0] sample,
    input  logic        wr_cycle,
    input  logic        wr_bus,
    input  logic [31:0] wdata,
    output logic [31:0] cycle_val,
    output logic [31:0] bus_val
);

    localparam logic [31:0] BUS_MASK = 32'hFFFF_FF80;
    localparam logic [31:0] BUS_STEP = 32'd128;

    logic [31:0] cyc_q;
    logic [31:0] bus_q;
    logic        wrap;

    assign wrap = sample_valid && !wr_cycle && (sample < cyc_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
            bus_q <= '0;
        end else begin
            if (wr_cycle)
                cyc_q <= wdata;
            else if (sample_valid)
                cyc_q <= sample;
            if (wr_bus)
                bus_q <= wdata & BUS_MASK;
            else if (wrap)
                bus_q <= bus_q + BUS_STEP;
        end
    end

    assign cycle_val = cyc_q;
    assign bus_val   = bus_q | (cyc_q >> 25);

    assert_wrap_adds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && !wr_cycle && !wr_bus && (sample < cyc_q))
        |=> (bus_q == $past(bus_q) + BUS_STEP));

    assert_no_wrap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_bus && !(sample_valid && sample < cyc_q)) |=> $stable(bus_q));

endmodule

// File: rtl/sbus_csr_regfile.sv
module sbus_csr_regfile
    import sbus_csr_pkg::*;
#(
    parameter int          OFS_W         = 10,
    parameter int          LEN_W         = 12,
    parameter int          EXP_W         = 24,
    parameter logic [15:0] RESET_NODE_ID = 16'hFFC2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [OFS_W-1:0] req_offset,
    input  logic [LEN_W-1:0] req_len,
    input  logic [31:0]      req_wdata,
    input  logic             cyc_sample_valid,
    input  logic [31:0]      cyc_sample,
    input  logic [31:0]      res_bm_id,
    input  logic [31:0]      res_bw_avail,
    input  logic [31:0]      res_chan_hi,
    input  logic [31:0]      res_chan_lo,
    output logic             rsp_valid,
    output logic [3:0]       rsp_code,
    output logic [31:0]      rsp_rdata,
    output logic [15:0]      node_id,
    output logic [EXP_W-1:0] expire_us
);

    localparam logic [12:0] SPLIT_LO_RESET = 13'd800;
    localparam logic [31:0] BCAST_RESET    = 32'h8000_001F;
    localparam int          BCAST_VALID    = 30;

    ctl_state_e  state_q, state_d;
    regsel_e     sel;
    rcode_e      code;
    logic        wr_ok;
    logic [15:0] node_q;
    logic [2:0]  split_hi_q;
    logic [12:0] split_lo_q;
    logic [31:0] bcast_q;
    logic [31:0] cycle_val, bus_val;
    logic [31:0] rd_val;
    logic [3:0]  code_q;
    logic [31:0] rdata_q;

    sbus_csr_decode #(.OFS_W(OFS_W), .LEN_W(LEN_W)) u_decode (
        .offset   (req_offset),
        .len      (req_len),
        .is_write (req_write),
        .sel      (sel),
        .code     (code)
    );

    assign wr_ok = req_valid && req_write && (code == RC_COMPLETE);

    sbus_csr_bustime u_bustime (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (cyc_sample_valid),
        .sample       (cyc_sample),
        .wr_cycle     (wr_ok && sel == SEL_CYCLE),
        .wr_bus       (wr_ok && sel == SEL_BUS),
        .wdata        (req_wdata),
        .cycle_val    (cycle_val),
        .bus_val      (bus_val)
    );

    sbus_csr_expiry #(.EXP_W(EXP_W)) u_expiry (
        .clk       (clk),
        .rst_n     (rst_n),
        .secs      (split_hi_q),
        .ticks     (split_lo_q),
        .expire_us (expire_us)
    );

    // Control state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
        endcase
    end

    // Writable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            node_q     <= RESET_NODE_ID;
            split_hi_q <= '0;
            split_lo_q <= SPLIT_LO_RESET;
            bcast_q    <= BCAST_RESET;
        end else if (wr_ok) begin
            unique case (sel)
                SEL_NODE:     node_q     <= {req_wdata[31:22], node_q[5:0]};
                SEL_SPLIT_HI: split_hi_q <= req_wdata[2:0];
                SEL_SPLIT_LO: split_lo_q <= req_wdata[31:19];
                SEL_BCAST:    bcast_q[BCAST_VALID] <= req_wdata[BCAST_VALID];
                default:      ;
            endcase
        end
    end

    // Read multiplexer
    always_comb begin
        unique case (sel)
            SEL_NODE:     rd_val = {node_q, 16'h0000};
            SEL_SPLIT_HI: rd_val = {29'd0, split_hi_q};
            SEL_SPLIT_LO: rd_val = {split_lo_q, 19'd0};
            SEL_CYCLE:    rd_val = cycle_val;
            SEL_BUS:      rd_val = bus_val;
            SEL_BM:       rd_val = res_bm_id;
            SEL_BW:       rd_val = res_bw_avail;
            SEL_CHHI:     rd_val = res_chan_hi;
            SEL_CHLO:     rd_val = res_chan_lo;
            SEL_BCAST:    rd_val = bcast_q;
            default:      rd_val = '0;
        endcase
    end

    // Response outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= RC_COMPLETE;
            rdata_q <= '0;
        end else if (req_valid) begin
            code_q  <= code;
            rdata_q <= (!req_write && code == RC_COMPLETE) ? rd_val : 32'd0;
        end
    end

    assign rsp_valid = (state_q == ST_RESP);
    assign rsp_code  = code_q;
    assign rsp_rdata = rdata_q;
    assign node_id   = node_q;

    assert_rsp_next_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_rsp_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_unaligned_type_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_offset[1:0] != 2'b00 || req_len[1:0] != 2'b00))
        |=> (rsp_code == 4'd6));

    assert_bcast_fixed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($stable(bcast_q[29:0]) && $stable(bcast_q[31])));

    assert_node_field_kept_R12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(node_id[5:0]));

endmodule

// File: tb/sbus_csr_regfile_tb.sv
module sbus_csr_regfile_tb;

    localparam int OFS_W = 10;
    localparam int LEN_W = 12;
    localparam int EXP_W = 24;
    localparam logic [15:0] RST_NODE = 16'hFFC2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic [OFS_W-1:0] req_offset = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic [31:0]      req_wdata = '0;
    logic             cyc_sample_valid = 1'b0;
    logic [31:0]      cyc_sample = '0;
    logic [31:0]      res_bm_id = 32'h0000_003F;
    logic [31:0]      res_bw_avail = 32'd4915;
    logic [31:0]      res_chan_hi = 32'hFFFF_FFFE;
    logic [31:0]      res_chan_lo = 32'hFFFF_FFFF;
    logic             rsp_valid;
    logic [3:0]       rsp_code;
    logic [31:0]      rsp_rdata;
    logic [15:0]      node_id;
    logic [EXP_W-1:0] expire_us;

    sbus_csr_regfile #(.OFS_W(OFS_W), .LEN_W(LEN_W), .EXP_W(EXP_W),
                       .RESET_NODE_ID(RST_NODE)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_offset(req_offset), .req_len(req_len), .req_wdata(req_wdata),
        .cyc_sample_valid(cyc_sample_valid), .cyc_sample(cyc_sample),
        .res_bm_id(res_bm_id), .res_bw_avail(res_bw_avail),
        .res_chan_hi(res_chan_hi), .res_chan_lo(res_chan_lo),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata),
        .node_id(node_id), .expire_us(expire_us)
    );

    always #10 clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;

    // bench model of register contents
    logic [15:0] m_node;
    logic [2:0]  m_shi;
    logic [12:0] m_slo;
    logic [31:0] m_cyc, m_bus, m_bc;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [3:0] exp_code(input bit wr, input int ofs, input int len);
        if ((ofs % 4) != 0 || (len % 4) != 0) return 4'd6;
        case (ofs)
            'h000, 'h004, 'h008, 'h018, 'h01C, 'h200, 'h204, 'h234: return 4'd0;
            'h00C: return wr ? 4'd0 : 4'd6;
            'h21C, 'h220, 'h224, 'h228: return wr ? 4'd6 : 4'd0;
            default: return 4'd7;
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input int ofs);
        case (ofs)
            'h008: return {m_node, 16'h0};
            'h018: return {29'd0, m_shi};
            'h01C: return {m_slo, 19'd0};
            'h200: return m_cyc;
            'h204: return m_bus | (m_cyc >> 25);
            'h21C: return res_bm_id;
            'h220: return res_bw_avail;
            'h224: return res_chan_hi;
            'h228: return res_chan_lo;
            'h234: return m_bc;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] exp_expire(input logic [2:0] s, input logic [12:0] t);
        int v;
        v = int'(s) * 1000000 + int'(t) * 125;
        return (v < 100000) ? 32'd100000 : 32'(v);
    endfunction

    // One request; response sampled at the following falling edge.
    task automatic access(input bit wr, input int ofs, input int len, input logic [31:0] wd,
                          output logic [3:0] code, output logic [31:0] rd, output bit vld);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr;
        req_offset = OFS_W'(ofs); req_len = LEN_W'(len); req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        code = rsp_code; rd = rsp_rdata; vld = rsp_valid;
        if (wr && exp_code(1'b1, ofs, len) == 4'd0) begin
            case (ofs)
                'h008: m_node = {wd[31:22], m_node[5:0]};
                'h018: m_shi = wd[2:0];
                'h01C: m_slo = wd[31:19];
                'h200: m_cyc = wd;
                'h204: m_bus = wd & 32'hFFFF_FF80;
                'h234: m_bc[30] = wd[30];
                default: ;
            endcase
        end
    endtask

    task automatic feed_sample(input logic [31:0] v);
        @(negedge clk);
        cyc_sample_valid = 1'b1; cyc_sample = v;
        @(negedge clk);
        cyc_sample_valid = 1'b0;
        if (v < m_cyc) m_bus = m_bus + 32'd128;
        m_cyc = v;
    endtask

    task automatic rd_check(input string req, input int ofs);
        logic [3:0] c; logic [31:0] d; bit v;
        access(1'b0, ofs, 4, 32'd0, c, d, v);
        chk({req, " code"}, {28'd0, c}, {28'd0, exp_code(1'b0, ofs, 4)});
        chk({req, " data"}, d, exp_read(ofs));
    endtask

    task automatic wr_check(input string req, input int ofs, input logic [31:0] wd);
        logic [3:0] c; logic [31:0] d; bit v;
        access(1'b1, ofs, 4, wd, c, d, v);
        chk({req, " wcode"}, {28'd0, c}, {28'd0, exp_code(1'b1, ofs, 4)});
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: got %0d cycles expected < 150000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [3:0] c; logic [31:0] d; bit v;
        m_node = RST_NODE; m_shi = 3'd0; m_slo = 13'd800;
        m_cyc = 32'd0; m_bus = 32'd0; m_bc = 32'h8000_001F;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state, R1/R6/R7/R11/R12
        chk("R1 idle after reset", {31'd0, rsp_valid}, 32'd0);
        chk("R7 reset expire", 32'(expire_us), 32'd100000);
        chk("R12 reset node_id", {16'd0, node_id}, {16'd0, RST_NODE});
        rd_check("R6 reset split lo", 'h01C);
        rd_check("R6 reset split hi", 'h018);
        rd_check("R11 reset bcast", 'h234);

        // R1: response valid exactly one cycle after strobe
        access(1'b0, 'h008, 4, 32'd0, c, d, v);
        chk("R1 rsp_valid", {31'd0, v}, 32'd1);
        @(negedge clk);
        chk("R1 rsp_valid drops", {31'd0, rsp_valid}, 32'd0);

        // R2/R3/R4/R5: read sweep over every offset
        for (int o = 0; o < 1024; o++) rd_check("R2 R3 R4 R5 sweep", o);
        // R2: length sweep at aligned offset
        for (int l = 0; l < 16; l++) begin
            access(1'b0, 'h200, l, 32'd0, c, d, v);
            chk("R2 length", {28'd0, c}, {28'd0, exp_code(1'b0, 'h200, l)});
        end
        // R3: busy timeout write
        wr_check("R3 busy write", 'h210, 32'hFFFF_FFFF);
        // R4: resource writes refused, values unchanged at port
        wr_check("R4 bm write", 'h21C, 32'h0);
        wr_check("R4 bw write", 'h220, 32'h0);
        wr_check("R4 chhi write", 'h224, 32'h0);
        wr_check("R4 chlo write", 'h228, 32'h0);
        res_bw_avail = 32'd1234;
        rd_check("R4 bw passthrough", 'h220);
        // R5: reset-start and state writes complete with no effect
        wr_check("R5 reset write", 'h00C, 32'hFFFF_FFFF);
        wr_check("R5 state set", 'h004, 32'hFFFF_FFFF);
        rd_check("R5 state read", 'h000);
        rd_check("R5 node unchanged", 'h008);

        // R6/R7: split masks and expiry grid
        wr_check("R6 split hi ones", 'h018, 32'hFFFF_FFFF);
        rd_check("R6 split hi mask", 'h018);
        wr_check("R6 split lo ones", 'h01C, 32'hFFFF_FFFF);
        rd_check("R6 split lo mask", 'h01C);
        chk("R7 max expire", 32'(expire_us), exp_expire(3'd7, 13'h1FFF));
        for (int s = 0; s < 8; s++) begin
            for (int k = 0; k < 6; k++) begin
                logic [12:0] t;
                case (k)
                    0: t = 13'd0;   1: t = 13'd1;   2: t = 13'd799;
                    3: t = 13'd800; 4: t = 13'd801; default: t = 13'd8191;
                endcase
                wr_check("R6 hi", 'h018, 32'(s));
                wr_check("R6 lo", 'h01C, {t, 19'h7FFFF});
                chk("R7 expire", 32'(expire_us), exp_expire(3'(s), t));
            end
        end

        // R8/R9/R10: cycle samples and bus time
        for (int i = 1; i <= 8; i++) begin
            feed_sample(32'(i) * 32'h0100_0000);
            rd_check("R9 rising no wrap", 'h204);
        end
        rd_check("R8 cycle sample", 'h200);
        feed_sample(32'h0000_0010);
        rd_check("R9 wrap adds 128", 'h204);
        feed_sample(32'h0000_0008);
        rd_check("R9 second wrap", 'h204);
        feed_sample(32'hFE00_0000);
        rd_check("R10 or term", 'h204);
        wr_check("R10 bus write", 'h204, 32'hFFFF_FFFF);
        rd_check("R10 bus mask", 'h204);
        wr_check("R8 cycle write", 'h200, 32'h0000_0100);
        rd_check("R8 cycle written", 'h200);
        rd_check("R10 after cycle write", 'h204);
        feed_sample(32'h0000_00FF);
        rd_check("R9 wrap after write", 'h204);
        // R8: write wins over simultaneous sample
        @(negedge clk);
        cyc_sample_valid = 1'b1; cyc_sample = 32'h0000_0001;
        req_valid = 1'b1; req_write = 1'b1; req_offset = OFS_W'('h200);
        req_len = LEN_W'(4); req_wdata = 32'h0ABC_0000;
        @(negedge clk);
        cyc_sample_valid = 1'b0; req_valid = 1'b0;
        m_cyc = 32'h0ABC_0000;
        rd_check("R8 write priority", 'h200);
        rd_check("R9 no wrap on write", 'h204);

        // R11: broadcast only valid bit
        wr_check("R11 bcast ones", 'h234, 32'hFFFF_FFFF);
        rd_check("R11 bcast set", 'h234);
        wr_check("R11 bcast zeros", 'h234, 32'h0);
        rd_check("R11 bcast clear", 'h234);

        // R12: node-ID bus field
        wr_check("R12 node write", 'h008, 32'h0000_FFFF);
        rd_check("R12 node bus cleared", 'h008);
        chk("R12 node port", {16'd0, node_id}, {16'd0, m_node});
        wr_check("R12 node write2", 'h008, 32'hA5C0_0000);
        rd_check("R12 node bus set", 'h008);
        chk("R12 node port2", {16'd0, node_id}, {16'h0, 16'hA5C2});

        // R1: back-to-back requests
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_offset = OFS_W'('h234); req_len = LEN_W'(4);
        @(negedge clk);
        chk("R1 b2b first", {27'd0, rsp_valid, rsp_code}, {27'd0, 1'b1, 4'd0});
        req_offset = OFS_W'('h210);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1 b2b second", {27'd0, rsp_valid, rsp_code}, {27'd0, 1'b1, 4'd7});
        @(negedge clk);
        chk("R1 b2b idle", {31'd0, rsp_valid}, 32'd0);

        finish_run();
    end

endmodule